// File: doc/BRIEF.md
# GMII Test Frame Source

This block is a synthesizable traffic source for exercising the receive side of an Ethernet MAC. It drives a byte-wide GMII transmit interface (data, enable, error) and emits a fixed number of complete frames after reset. Every frame carries a preamble and start delimiter, constant destination and source addresses, a length/type field, an incrementing payload and a CRC-32 frame check sequence. When the last frame is done it parks the interface and raises a done flag.

Elaboration parameters pick the test pattern. The payload length sweeps upward from a start value by a step and falls back to the start value once the maximum is exceeded. Short frames can be padded to the Ethernet minimum. A periodic pattern of plain, single-tagged and double-tagged frames can be interleaved. The gap between frames can be fixed or can vary pseudo-randomly. Every frame can be flagged with the error line. An external pause input can hold back new frames. The maximum length is not capped at the receiver's limit, so oversize frames can be produced on purpose.

Top module: `gmii_frame_gen`

## Requirements
- R1: Exactly NUM_FRAMES frames are sent. `gen_done` is low until the cycle in which `gmii_tx_en` drops after the last frame. From that cycle on, `gen_done` stays high and `gmii_tx_en` stays low.
- R2: A frame opens with seven 0x55 bytes followed by one 0xD5 byte. `gmii_tx_en` is high without a break from the first of these bytes through the last FCS byte.
- R3: After the delimiter come the 6 destination address bytes and then the 6 source address bytes, each address sent most significant byte first.
- R4: The length/type field directly precedes the payload and carries the payload length, high byte first. The first frame's payload length is LEN_START. Each later frame adds LEN_STEP. A sum equal to LEN_MAX is used as is. A sum above LEN_MAX is replaced by LEN_START.
- R5: The payload bytes count up from 0x00, modulo 256, and restart at 0x00 in every frame.
- R6: With PAD_EN set, zero bytes follow the payload until the bytes from destination address through FCS number at least 64. With PAD_EN clear, no filler is added.
- R7: With VLAN_PERIOD = N > 0, the frame pattern repeats as N plain frames, then one frame with tag 0x8100 + CTAG_TCI, then one frame with 0x88A8 + STAG_TCI followed by 0x8100 + CTAG_TCI. Tags sit between the source address and the length/type field. With N = 0, every frame is plain.
- R8: The last four bytes are the reflected CRC-32 (polynomial 0x04C11DB7, seed all ones, result inverted) over destination address through padding, sent least significant byte first.
- R9: Between two frames `gmii_tx_en` is low for at least IPG cycles. With VAR_IPG clear and no pause, it is low for exactly IPG cycles.
- R10: With VAR_IPG set, each gap is IPG plus a pseudo-random 0 to 15 cycles, and the gap length varies from frame to frame.
- R11: With ERR_EN set, `gmii_tx_er` is high on every byte of every frame. With ERR_EN clear, it is never high. While `gmii_tx_en` is low, it is always low.
- R12: With PAUSE_EN set, a frame whose first byte appears on the pins after clock edge t+2 is started only if `pause_req` was low at edge t. A frame already under way always runs to its end.
- R13: With PAUSE_EN clear, `pause_req` has no effect: frames start while it is held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pause_req | input | 1 | Hold-off request for new frames |
| gmii_txd | output | 8 | Transmit data byte |
| gmii_tx_en | output | 1 | Transmit enable, high across a frame |
| gmii_tx_er | output | 1 | Transmit error marker |
| gen_done | output | 1 | All frames sent |

## Verification
Two events can land on the same edge: the gap counter reaching its end and the pause input being raised. Whether the frame is released or held then depends only on the pause value at that edge. The bench raises pause for a long window that opens while one instance is mid-frame and closes in the middle of its held gap. Every frame start is compared against the pause level two samples earlier, and a gap that saw a pause is exempt only from the exact-length check, never from the minimum. A second instance with the pause response disabled receives the same window and must start frames inside it. That instance also carries error marking and variable gaps, so error marking on the first byte of a frame and the pseudo-random gap end fall together.

// File: rtl/gfg_pkg.sv
package gfg_pkg;

   typedef enum logic [2:0] {
      ST_GAP,
      ST_PRE,
      ST_BODY,
      ST_FCS,
      ST_DONE
   } gfg_state_e;

   typedef enum logic [1:0] {
      FK_BASIC,
      FK_CTAG,
      FK_STACK
   } gfg_kind_e;

   localparam logic [31:0] CRC_POLY_REFL = 32'hEDB8_8320;
   localparam logic [15:0] TPID_CUST     = 16'h8100;
   localparam logic [15:0] TPID_SERV     = 16'h88A8;
   localparam logic [7:0]  BYTE_PRE      = 8'h55;
   localparam logic [7:0]  BYTE_SFD      = 8'hD5;

   // one byte of the LSB-first CRC-32 update
   function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
      logic [31:0] r;
      r = c ^ {24'h0, d};
      for (int i = 0; i < 8; i++) begin
         r = r[0] ? ((r >> 1) ^ CRC_POLY_REFL) : (r >> 1);
      end
      return r;
   endfunction

endpackage

// File: rtl/gfg_crc32.sv
module gfg_crc32
   import gfg_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int CRC_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              init_i,
   input  logic              en_i,
   input  logic [DATA_W-1:0] data_i,
   output logic [CRC_W-1:0]  crc_o
);

   if (DATA_W != 8 || CRC_W != 32) begin : g_bad_width
      $error("gfg_crc32 supports only 8-bit data and a 32-bit remainder");
   end

   logic [CRC_W-1:0] crc_q;

   always_ff @(posedge clk) begin
      if (!rst_n || init_i) begin
         crc_q <= '1;
      end else if (en_i) begin
         crc_q <= crc_step(crc_q, data_i);
      end
   end

   assign crc_o = crc_q;

endmodule

// File: rtl/gfg_frame_seq.sv
module gfg_frame_seq
   import gfg_pkg::*;
#(
   parameter int NUM_FRAMES  = 5,
   parameter int LEN_START   = 100,
   parameter int LEN_STEP    = 1,
   parameter int LEN_MAX     = 1500,
   parameter int VLAN_PERIOD = 0,
   parameter int LEN_W       = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv_i,
   output logic [LEN_W-1:0] len_o,
   output gfg_kind_e        kind_o,
   output logic             last_o
);

   localparam int CNT_W = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1;

   logic [CNT_W-1:0] idx_q;
   logic [LEN_W-1:0] len_q;
   logic [LEN_W:0]   len_sum;

   assign len_sum = {1'b0, len_q} + (LEN_W+1)'(LEN_STEP);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q <= '0;
         len_q <= LEN_W'(LEN_START);
      end else if (adv_i) begin
         idx_q <= idx_q + CNT_W'(1);
         len_q <= (len_sum > (LEN_W+1)'(LEN_MAX)) ? LEN_W'(LEN_START) : len_sum[LEN_W-1:0];
      end
   end

   assign len_o  = len_q;
   assign last_o = (idx_q == CNT_W'(NUM_FRAMES - 1));

   if (VLAN_PERIOD == 0) begin : g_plain
      assign kind_o = FK_BASIC;
   end else begin : g_cycle
      localparam int CYC_W = $clog2(VLAN_PERIOD + 2);
      logic [CYC_W-1:0] cyc_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            cyc_q <= '0;
         end else if (adv_i) begin
            cyc_q <= (cyc_q == CYC_W'(VLAN_PERIOD + 1)) ? '0 : cyc_q + CYC_W'(1);
         end
      end

      always_comb begin
         if (cyc_q < CYC_W'(VLAN_PERIOD))       kind_o = FK_BASIC;
         else if (cyc_q == CYC_W'(VLAN_PERIOD)) kind_o = FK_CTAG;
         else                                   kind_o = FK_STACK;
      end
   end

endmodule

// File: rtl/gfg_gap_gen.sv
module gfg_gap_gen #(
   parameter int          IPG       = 12,
   parameter bit          VAR_IPG   = 1'b0,
   parameter int          GAP_W     = 5,
   parameter logic [15:0] LFSR_SEED = 16'hACE1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv_i,
   output logic [GAP_W-1:0] gap_o
);

   if (LFSR_SEED == 16'h0) begin : g_bad_seed
      $error("gfg_gap_gen needs a nonzero LFSR seed");
   end

   logic [15:0] lfsr_q;
   logic        fb;
   logic [3:0]  extra;

   assign fb = lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lfsr_q <= LFSR_SEED;
      end else if (adv_i) begin
         lfsr_q <= {lfsr_q[14:0], fb};
      end
   end

   if (VAR_IPG) begin : g_var
      assign extra = lfsr_q[3:0];
   end else begin : g_fixed
      assign extra = 4'd0;
   end

   assign gap_o = GAP_W'(IPG) + GAP_W'(extra);

endmodule

// File: rtl/gmii_frame_gen.sv
module gmii_frame_gen
   import gfg_pkg::*;
#(
   parameter int          NUM_FRAMES  = 5,
   parameter int          LEN_START   = 100,
   parameter int          LEN_STEP    = 1,
   parameter int          LEN_MAX     = 1500,
   parameter bit          PAD_EN      = 1'b1,
   parameter int          VLAN_PERIOD = 0,
   parameter int          IPG         = 12,
   parameter bit          VAR_IPG     = 1'b0,
   parameter bit          ERR_EN      = 1'b0,
   parameter bit          PAUSE_EN    = 1'b1,
   parameter logic [47:0] DST_MAC     = 48'h02_00_00_00_00_01,
   parameter logic [47:0] SRC_MAC     = 48'h02_00_00_00_00_02,
   parameter logic [15:0] CTAG_TCI    = 16'h0005,
   parameter logic [15:0] STAG_TCI    = 16'h000A,
   parameter int          MIN_BODY    = 60
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pause_req,
   output logic [7:0] gmii_txd,
   output logic       gmii_tx_en,
   output logic       gmii_tx_er,
   output logic       gen_done
);

   localparam int LEN_W   = 16;
   localparam int POS_W   = LEN_W + 2;
   localparam int GAP_W   = $clog2(IPG + 16 + 1);
   localparam int PRE_LEN = 8;
   localparam int FCS_LEN = 4;
   localparam int ADDR_END = 12;

   // elaboration-time parameter checks
   if (NUM_FRAMES < 1) begin : g_bad_count
      $error("NUM_FRAMES must be at least 1");
   end
   if (LEN_START < 0 || LEN_STEP < 0) begin : g_bad_len
      $error("LEN_START and LEN_STEP must not be negative");
   end
   if (LEN_MAX < LEN_START || LEN_MAX > 65535) begin : g_bad_max
      $error("LEN_MAX must lie between LEN_START and 65535");
   end
   if (IPG < 2) begin : g_bad_ipg
      $error("IPG must be at least 2");
   end
   if (VLAN_PERIOD < 0) begin : g_bad_vlan
      $error("VLAN_PERIOD must not be negative");
   end

   gfg_state_e       state_q, state_d;
   logic [POS_W-1:0] pos_q, pos_d;
   logic [GAP_W-1:0] gcnt_q, gcnt_d;

   logic [LEN_W-1:0] cur_len;
   gfg_kind_e        cur_kind;
   logic             last_frame;
   logic [GAP_W-1:0] gap_len;
   logic [31:0]      crc;
   logic             frame_end;
   logic             pause_blk;

   logic [POS_W-1:0] hdr_len, pay_end, body_end, rel;
   logic [63:0]      tag_word;
   logic [7:0]       body_byte, tx_byte;
   logic [31:0]      fcs_word;
   logic             active;

   assign pause_blk = PAUSE_EN && pause_req;
   assign frame_end = (state_q == ST_FCS) && (pos_q == POS_W'(FCS_LEN - 1));

   gfg_frame_seq #(
      .NUM_FRAMES (NUM_FRAMES),
      .LEN_START  (LEN_START),
      .LEN_STEP   (LEN_STEP),
      .LEN_MAX    (LEN_MAX),
      .VLAN_PERIOD(VLAN_PERIOD),
      .LEN_W      (LEN_W)
   ) i_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .adv_i (frame_end),
      .len_o (cur_len),
      .kind_o(cur_kind),
      .last_o(last_frame)
   );

   gfg_gap_gen #(
      .IPG    (IPG),
      .VAR_IPG(VAR_IPG),
      .GAP_W  (GAP_W)
   ) i_gap (
      .clk  (clk),
      .rst_n(rst_n),
      .adv_i(frame_end),
      .gap_o(gap_len)
   );

   gfg_crc32 i_crc (
      .clk   (clk),
      .rst_n (rst_n),
      .init_i(state_q == ST_PRE),
      .en_i  (state_q == ST_BODY),
      .data_i(body_byte),
      .crc_o (crc)
   );

   // frame body layout for the current kind and length
   always_comb begin
      unique case (cur_kind)
         FK_CTAG:  begin hdr_len = POS_W'(18); tag_word = {TPID_CUST, CTAG_TCI, 32'h0}; end
         FK_STACK: begin hdr_len = POS_W'(22); tag_word = {TPID_SERV, STAG_TCI, TPID_CUST, CTAG_TCI}; end
         default:  begin hdr_len = POS_W'(14); tag_word = 64'h0; end
      endcase
      pay_end  = hdr_len + POS_W'(cur_len);
      body_end = (PAD_EN && pay_end < POS_W'(MIN_BODY)) ? POS_W'(MIN_BODY) : pay_end;
   end

   always_comb begin
      rel = '0;
      if (pos_q < POS_W'(6)) begin
         body_byte = DST_MAC[8*(5 - int'(pos_q[2:0])) +: 8];
      end else if (pos_q < POS_W'(ADDR_END)) begin
         body_byte = SRC_MAC[8*(11 - int'(pos_q[3:0])) +: 8];
      end else if (pos_q < hdr_len - POS_W'(2)) begin
         rel       = pos_q - POS_W'(ADDR_END);
         body_byte = tag_word[63 - 8*int'(rel[2:0]) -: 8];
      end else if (pos_q == hdr_len - POS_W'(2)) begin
         body_byte = cur_len[15:8];
      end else if (pos_q == hdr_len - POS_W'(1)) begin
         body_byte = cur_len[7:0];
      end else if (pos_q < pay_end) begin
         rel       = pos_q - hdr_len;
         body_byte = rel[7:0];
      end else begin
         body_byte = 8'h00;
      end
   end

   assign fcs_word = ~crc;

   always_comb begin
      unique case (state_q)
         ST_PRE:  tx_byte = (pos_q == POS_W'(PRE_LEN - 1)) ? BYTE_SFD : BYTE_PRE;
         ST_BODY: tx_byte = body_byte;
         ST_FCS:  tx_byte = fcs_word[8*int'(pos_q[1:0]) +: 8];
         default: tx_byte = 8'h00;
      endcase
      active = (state_q == ST_PRE) || (state_q == ST_BODY) || (state_q == ST_FCS);
   end

   // sequencing of preamble, body, check sequence and gap
   always_comb begin
      state_d = state_q;
      pos_d   = pos_q + POS_W'(1);
      gcnt_d  = gcnt_q;
      unique case (state_q)
         ST_GAP: begin
            pos_d = '0;
            if (gcnt_q >= gap_len - GAP_W'(1)) begin
               if (!pause_blk) state_d = ST_PRE;
            end else begin
               gcnt_d = gcnt_q + GAP_W'(1);
            end
         end
         ST_PRE: begin
            if (pos_q == POS_W'(PRE_LEN - 1)) begin
               state_d = ST_BODY;
               pos_d   = '0;
            end
         end
         ST_BODY: begin
            if (pos_q == body_end - POS_W'(1)) begin
               state_d = ST_FCS;
               pos_d   = '0;
            end
         end
         ST_FCS: begin
            if (frame_end) begin
               state_d = last_frame ? ST_DONE : ST_GAP;
               pos_d   = '0;
               gcnt_d  = '0;
            end
         end
         default: begin
            pos_d = pos_q;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= ST_GAP;
         pos_q      <= '0;
         gcnt_q     <= '0;
         gmii_txd   <= 8'h00;
         gmii_tx_en <= 1'b0;
         gmii_tx_er <= 1'b0;
         gen_done   <= 1'b0;
      end else begin
         state_q    <= state_d;
         pos_q      <= pos_d;
         gcnt_q     <= gcnt_d;
         gmii_txd   <= active ? tx_byte : 8'h00;
         gmii_tx_en <= active;
         gmii_tx_er <= active && ERR_EN;
         gen_done   <= (state_q == ST_DONE);
      end
   end

endmodule

// File: rtl/gfg_chk.sv
module gfg_chk #(
   parameter int IPG      = 12,
   parameter bit PAD_EN   = 1'b1,
   parameter bit PAUSE_EN = 1'b1
) (
   input logic       clk,
   input logic       rst_n,
   input logic       pause_req,
   input logic [7:0] txd,
   input logic       tx_en,
   input logic       tx_er,
   input logic       done
);

   int   gap_q;
   int   flen_q;
   logic en_q;
   logic seen_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gap_q  <= 0;
         flen_q <= 0;
         en_q   <= 1'b0;
         seen_q <= 1'b0;
      end else begin
         en_q   <= tx_en;
         gap_q  <= tx_en ? 0 : gap_q + 1;
         flen_q <= tx_en ? flen_q + 1 : 0;
         if (!tx_en && en_q) seen_q <= 1'b1;
      end
   end

   // R2
   preamble_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_en) |-> txd == 8'h55);

   // R11
   er_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_en |-> !tx_er);

   // R1
   done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> done);

   // R1
   done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !tx_en);

   // R12
   pause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (PAUSE_EN && $rose(tx_en)) |-> !$past(pause_req, 2));

   // R9
   gap_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_en && !en_q && seen_q) |-> gap_q >= IPG);

   // R6
   pad_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (PAD_EN && !tx_en && en_q) |-> flen_q >= 72);

endmodule

bind gmii_frame_gen gfg_chk #(
   .IPG     (IPG),
   .PAD_EN  (PAD_EN),
   .PAUSE_EN(PAUSE_EN)
) i_gfg_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .pause_req(pause_req),
   .txd      (gmii_txd),
   .tx_en    (gmii_tx_en),
   .tx_er    (gmii_tx_er),
   .done     (gen_done)
);

// File: tb/test_gmii_frame_gen.sv
`timescale 1ns/1ps

module gfg_mon #(
   parameter int          NUM_FRAMES  = 5,
   parameter int          LEN_START   = 100,
   parameter int          LEN_STEP    = 1,
   parameter int          LEN_MAX     = 1500,
   parameter bit          PAD_EN      = 1'b1,
   parameter int          VLAN_PERIOD = 0,
   parameter int          IPG         = 12,
   parameter bit          VAR_IPG     = 1'b0,
   parameter bit          ERR_EN      = 1'b0,
   parameter bit          PAUSE_EN    = 1'b1,
   parameter logic [47:0] DST         = 48'h0,
   parameter logic [47:0] SRC         = 48'h0,
   parameter logic [15:0] CTCI        = 16'h0,
   parameter logic [15:0] STCI        = 16'h0
) (
   input logic       clk,
   input logic       rst_n,
   input logic       pause,
   input logic [7:0] txd,
   input logic       en,
   input logic       er,
   input logic       done
);

   logic [7:0] exp_q[$];
   string      tag_q[$];
   logic [7:0] body[$];
   string      btag[$];

   int checks = 0;
   int errs = 0;
   int frames_seen = 0;
   int gap = 0;
   int cur_len = LEN_START;
   int ignored_starts = 0;
   int first_gap = 0;
   bit gap_varied = 0;
   bit touched = 0;
   bit prev_en = 0;
   bit p_d1 = 0;
   bit p_d2 = 0;

   task automatic chk(bit ok, string req, string what, int act, int expv);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s %m: %s actual=%0d expected=%0d", req, what, act, expv);
      end
   endtask

   task automatic bpush(logic [7:0] b, string t);
      body.push_back(b);
      btag.push_back(t);
   endtask

   task automatic build_frame(int len, int kind);
      logic [15:0] l16;
      logic [31:0] c;
      l16 = 16'(len);
      body.delete(); btag.delete(); exp_q.delete(); tag_q.delete();
      for (int i = 0; i < 7; i++) begin exp_q.push_back(8'h55); tag_q.push_back("R2"); end
      exp_q.push_back(8'hD5); tag_q.push_back("R2");
      for (int i = 0; i < 6; i++) bpush(DST[47-8*i -: 8], "R3");
      for (int i = 0; i < 6; i++) bpush(SRC[47-8*i -: 8], "R3");
      if (kind == 1) begin
         bpush(8'h81, "R7"); bpush(8'h00, "R7"); bpush(CTCI[15:8], "R7"); bpush(CTCI[7:0], "R7");
      end else if (kind == 2) begin
         bpush(8'h88, "R7"); bpush(8'hA8, "R7"); bpush(STCI[15:8], "R7"); bpush(STCI[7:0], "R7");
         bpush(8'h81, "R7"); bpush(8'h00, "R7"); bpush(CTCI[15:8], "R7"); bpush(CTCI[7:0], "R7");
      end
      bpush(l16[15:8], "R4");
      bpush(l16[7:0], "R4");
      for (int i = 0; i < len; i++) bpush(8'(i), "R5");
      if (PAD_EN) while (body.size() < 60) bpush(8'h00, "R6");
      c = 32'hFFFF_FFFF;
      foreach (body[k]) begin
         c = c ^ {24'h0, body[k]};
         for (int j = 0; j < 8; j++) c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
         exp_q.push_back(body[k]);
         tag_q.push_back(btag[k]);
      end
      c = ~c;
      for (int i = 0; i < 4; i++) begin exp_q.push_back(c[8*i +: 8]); tag_q.push_back("R8"); end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         if (en && !prev_en) begin
            int kind;
            chk(frames_seen < NUM_FRAMES, "R1", "frame beyond configured count", frames_seen, NUM_FRAMES);
            if (PAUSE_EN) chk(!p_d2, "R12", "frame admitted while paused", int'(p_d2), 0);
            else if (p_d2) ignored_starts++;
            if (frames_seen > 0) begin
               chk(gap >= IPG, "R9", "gap below minimum", gap, IPG);
               if (VAR_IPG) begin
                  chk(gap <= IPG + 15, "R10", "gap above variable limit", gap, IPG + 15);
                  if (frames_seen == 1) first_gap = gap;
                  else if (gap != first_gap) gap_varied = 1;
               end else if (!touched) begin
                  chk(gap == IPG, "R9", "constant gap length", gap, IPG);
               end
            end
            if (VLAN_PERIOD == 0) kind = 0;
            else if (frames_seen % (VLAN_PERIOD + 2) < VLAN_PERIOD) kind = 0;
            else if (frames_seen % (VLAN_PERIOD + 2) == VLAN_PERIOD) kind = 1;
            else kind = 2;
            build_frame(cur_len, kind);
            cur_len += LEN_STEP;
            if (cur_len > LEN_MAX) cur_len = LEN_START;
            touched = 0;
         end
         if (en) begin
            if (exp_q.size() == 0) begin
               chk(0, "R2", "tx_en held past frame end", 1, 0);
            end else begin
               logic [7:0] b;
               string t;
               b = exp_q.pop_front();
               t = tag_q.pop_front();
               chk(txd == b, t, "frame byte", int'(txd), int'(b));
            end
            chk(er == ERR_EN, "R11", "tx_er inside frame", int'(er), int'(ERR_EN));
         end else begin
            chk(!er, "R11", "tx_er outside frame", int'(er), 0);
            if (prev_en) begin
               chk(exp_q.size() == 0, "R2", "frame ended with bytes missing", exp_q.size(), 0);
               frames_seen++;
               gap = 1;
            end else begin
               gap++;
            end
            if (pause) touched = 1;
         end
         chk(done == (frames_seen == NUM_FRAMES), "R1", "done flag", int'(done), int'(frames_seen == NUM_FRAMES));
         p_d2 = p_d1;
         p_d1 = pause;
         prev_en = en;
      end
   end

endmodule

module test_gmii_frame_gen;

   localparam logic [47:0] DST  = 48'h02_11_22_33_44_55;
   localparam logic [47:0] SRC  = 48'h02_66_77_88_99_AA;
   localparam logic [15:0] CTCI = 16'h2007;
   localparam logic [15:0] STCI = 16'h3064;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pause = 1'b0;

   logic [7:0] txd_a, txd_b;
   logic       en_a, er_a, done_a, en_b, er_b, done_b;

   int checks = 0;
   int errs = 0;
   bit timeout = 0;

   always #4 clk = ~clk;

   gmii_frame_gen #(
      .NUM_FRAMES(9), .LEN_START(40), .LEN_STEP(10), .LEN_MAX(60), .PAD_EN(1'b1),
      .VLAN_PERIOD(2), .IPG(12), .VAR_IPG(1'b0), .ERR_EN(1'b0), .PAUSE_EN(1'b1),
      .DST_MAC(DST), .SRC_MAC(SRC), .CTAG_TCI(CTCI), .STAG_TCI(STCI)
   ) i_gmii_frame_gen (
      .clk(clk), .rst_n(rst_n), .pause_req(pause),
      .gmii_txd(txd_a), .gmii_tx_en(en_a), .gmii_tx_er(er_a), .gen_done(done_a)
   );

   gmii_frame_gen #(
      .NUM_FRAMES(6), .LEN_START(10), .LEN_STEP(3), .LEN_MAX(16), .PAD_EN(1'b0),
      .VLAN_PERIOD(0), .IPG(12), .VAR_IPG(1'b1), .ERR_EN(1'b1), .PAUSE_EN(1'b0),
      .DST_MAC(DST), .SRC_MAC(SRC), .CTAG_TCI(CTCI), .STAG_TCI(STCI)
   ) i_gmii_frame_gen_b (
      .clk(clk), .rst_n(rst_n), .pause_req(pause),
      .gmii_txd(txd_b), .gmii_tx_en(en_b), .gmii_tx_er(er_b), .gen_done(done_b)
   );

   gfg_mon #(
      .NUM_FRAMES(9), .LEN_START(40), .LEN_STEP(10), .LEN_MAX(60), .PAD_EN(1'b1),
      .VLAN_PERIOD(2), .IPG(12), .VAR_IPG(1'b0), .ERR_EN(1'b0), .PAUSE_EN(1'b1),
      .DST(DST), .SRC(SRC), .CTCI(CTCI), .STCI(STCI)
   ) mon_a (
      .clk(clk), .rst_n(rst_n), .pause(pause), .txd(txd_a), .en(en_a), .er(er_a), .done(done_a)
   );

   gfg_mon #(
      .NUM_FRAMES(6), .LEN_START(10), .LEN_STEP(3), .LEN_MAX(16), .PAD_EN(1'b0),
      .VLAN_PERIOD(0), .IPG(12), .VAR_IPG(1'b1), .ERR_EN(1'b1), .PAUSE_EN(1'b0),
      .DST(DST), .SRC(SRC), .CTCI(CTCI), .STCI(STCI)
   ) mon_b (
      .clk(clk), .rst_n(rst_n), .pause(pause), .txd(txd_b), .en(en_b), .er(er_b), .done(done_b)
   );

   task automatic chk(bit ok, string req, string what, int act, int expv);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, expv);
      end
   endtask

   initial begin
      repeat (5) @(posedge clk);
      @(negedge clk);
      // reset state: R1 done low, R2 enable low, R11 error low
      chk(!en_a && !en_b, "R2", "tx_en during reset", int'(en_a | en_b), 0);
      chk(!done_a && !done_b, "R1", "done during reset", int'(done_a | done_b), 0);
      chk(!er_a && !er_b, "R11", "tx_er during reset", int'(er_a | er_b), 0);
      chk(txd_a == 8'h00, "R2", "txd during reset", int'(txd_a), 0);
      @(posedge clk);
      #1 rst_n = 1'b1;

      fork
         begin
            // pause window overlapping both instances: R12 and R13
            repeat (150) @(posedge clk);
            #1 pause = 1'b1;
            repeat (250) @(posedge clk);
            #1 pause = 1'b0;
         end
         begin
            fork
               begin
                  wait (done_a && done_b);
               end
               begin
                  repeat (20000) @(posedge clk);
                  timeout = 1;
               end
            join_any
            disable fork;
         end
      join

      repeat (40) @(posedge clk);
      @(negedge clk);
      if (timeout) begin
         checks++;
         errs++;
         $display("FAIL R1: watchdog expired actual=%0d expected=%0d", 1, 0);
      end
      // R1 frame totals and idle after completion
      chk(mon_a.frames_seen == 9, "R1", "frames sent by first instance", mon_a.frames_seen, 9);
      chk(mon_b.frames_seen == 6, "R1", "frames sent by second instance", mon_b.frames_seen, 6);
      chk(!en_a && done_a, "R1", "first instance idle and done", int'(en_a), 0);
      // R13 pause ignored when disabled
      chk(mon_b.ignored_starts > 0, "R13", "frames started under ignored pause", mon_b.ignored_starts, 1);
      // R10 gap varies between frames
      chk(mon_b.gap_varied, "R10", "variable gap changed", int'(mon_b.gap_varied), 1);

      $display("  CHECKS %0d ERRORS %0d",
               checks + mon_a.checks + mon_b.checks, errs + mon_a.errs + mon_b.errs);
      $finish;
   end

endmodule